// File: doc/BRIEF.md
# Sticky Fault Status and Fault Address Capture

This block keeps the record a processor leaves behind when something goes wrong. Fault detectors elsewhere in the core send it one-cycle event pulses. Each pulse carries a cause code and, when the cause has one, the address involved. The block turns each pulse into a sticky flag. The flags live in three places:

- a 32-bit configurable status word;
- a hard-fault escalation word;
- an auxiliary word that latches raw input pulses.

The configurable status word has a fixed internal layout. Memory-management flags sit in bits 7:0, bus-fault flags in bits 15:8 and usage flags in bits 31:16. A handler can therefore read or clear any one of these groups on its own, using byte, halfword or word accesses selected by lane strobes.

Only two causes record an address: a data access violation and a precise data bus error. Both kinds share one address store. Each kind has its own valid flag in the status word. A capture of one kind sets that kind's valid flag and drops the other kind's valid flag, so software never trusts an address that has since been overwritten.

Software clears every flag by writing 1 to it. Writing 0 has no effect. If a hardware set and a software clear reach the same bit in the same cycle, the set wins.

Top module: `fault_capture`

## Requirements
- R1: With `flt_valid` high, cause code N sets bit N of the status word (register index 0) one cycle later. This holds for N in {0,1,3,4,8,9,10,11,12,16,17,18,19,24,25}. Any other code, including 7 and 15, changes no bit.
- R2: Status flags are sticky. Several flags can be set at once, and no flag falls without a software clear, except through the rule in R8.
- R3: A write to the status word (index 0), the escalation word (index 1) or the auxiliary word (index 4) clears exactly the bits written as 1 in the enabled lanes. Bits written as 0 keep their value.
- R4: Lane strobe bit k enables byte k (bits 8k+7:8k) for both writes and reads. Bytes whose strobe is low are left unchanged by a write and read back as 0.
- R5: When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R6: Cause 1 (data access violation) loads `flt_addr` into the shared address store and sets bit 7. Cause 9 (precise bus error) loads `flt_addr` and sets bit 15. Both index 2 and index 3 read the shared store.
- R7: Every other cause, including 0, 3, 4, 8, 10, 11 and 12, leaves the address store unchanged.
- R8: A capture by cause 1 clears bit 15, and a capture by cause 9 clears bit 7. Bits 7 and 15 are never both set.
- R9: In the escalation word, `hf_evt[2]` sets bit 31 (debug fault), `hf_evt[1]` sets bit 30 (forced escalation) and `hf_evt[0]` sets bit 1 (vector fetch fault). These bits are cleared by writing 1.
- R10: A one-cycle high level on `aux_in[k]` sets bit k of the auxiliary word, and that bit holds until software writes 1 to it.
- R11: Reserved bits read as 0 and ignore writes. Writes to the address store (indices 2 and 3) are ignored. Indices 5 to 7 read as 0.
- R12: After reset, every register reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_valid | input | 1 | Fault event pulse |
| flt_cause | input | 5 | Cause code, equal to the status bit it sets |
| flt_addr | input | FA_W | Faulting address for the event |
| hf_evt | input | 3 | Escalation events: [2] debug, [1] forced, [0] vector fetch |
| aux_in | input | AUX_W | Auxiliary fault inputs, latched on a high level |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write-one-to-clear, 0 = read |
| acc_idx | input | 3 | Word index: 0 status, 1 escalation, 2/3 address, 4 auxiliary |
| acc_be | input | 4 | Byte lane strobes |
| acc_wdata | input | 32 | Write data (ones clear) |
| rd_data | output | 32 | Read data for the addressed word, masked by lanes; 0 when no access |

## Verification
The bench builds the block with `AUX_W` = 8 and `FA_W` = 32. The narrow auxiliary word puts zero padding in its upper three lanes, so the bench can check that unused lanes read back as 0. The full-width address lets every bit of a captured address be compared. Random events and writes land on arbitrary indices and lane patterns. This exercises, in many combinations, the set-versus-clear collision, a single-lane clear of one flag group, and the alternation of the two address-capturing causes that flips the valid flags.

// File: rtl/fault_pkg.sv
package fault_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned LANES   = DW / 8;
  localparam int unsigned CAUSE_W = 5;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned HEV_W   = 3;

  // Causes that capture an address
  localparam logic [CAUSE_W-1:0] CAUSE_DACC    = 5'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_PRECISE = 5'd9;

  // Flag bits a cause code may set
  localparam logic [DW-1:0] CAUSE_MASK = 32'h030F_1F1B;
  localparam logic [DW-1:0] MVALID_M   = 32'h0000_0080;
  localparam logic [DW-1:0] BVALID_M   = 32'h0000_8000;
  localparam logic [DW-1:0] STAT_MASK  = CAUSE_MASK | MVALID_M | BVALID_M;
  localparam logic [DW-1:0] HARD_MASK  = 32'hC000_0002;

  typedef enum logic [IDX_W-1:0] {
    IDX_STAT  = 3'd0,
    IDX_HARD  = 3'd1,
    IDX_MADDR = 3'd2,
    IDX_BADDR = 3'd3,
    IDX_AUX   = 3'd4
  } reg_idx_e;

  function automatic logic [DW-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++) begin
      m[i*8 +: 8] = {8{be[i]}};
    end
    return m;
  endfunction

  function automatic logic [DW-1:0] cause_onehot(input logic v,
                                                 input logic [CAUSE_W-1:0] c);
    logic [DW-1:0] s;
    s = (DW'(1) << c) & CAUSE_MASK;
    return v ? s : '0;
  endfunction

  function automatic logic [DW-1:0] hard_set(input logic [HEV_W-1:0] e);
    return {e[2], e[1], 28'd0, e[0], 1'b0};
  endfunction
endpackage

// File: rtl/fault_w1c_reg.sv
module fault_w1c_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  // set is applied after clear, so a colliding set survives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= ((q_o & ~clr_i) | set_i) & KEEP;
  end
endmodule

// File: rtl/fault_status_bank.sv
module fault_status_bank
  import fault_pkg::*;
#(
  parameter int unsigned FA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flt_valid,
  input  logic [CAUSE_W-1:0] flt_cause,
  input  logic [FA_W-1:0]    flt_addr,
  input  logic [DW-1:0]      sw_clr,
  output logic [DW-1:0]      stat_q,
  output logic [FA_W-1:0]    addr_q,
  output logic               mem_cap,
  output logic               bus_cap
);
  logic [DW-1:0] set_vec;
  logic [DW-1:0] clr_vec;

  assign mem_cap = flt_valid && (flt_cause == CAUSE_DACC);
  assign bus_cap = flt_valid && (flt_cause == CAUSE_PRECISE);

  // a capture marks its own kind valid and invalidates the other kind
  assign set_vec = cause_onehot(flt_valid, flt_cause)
                 | (mem_cap ? MVALID_M : '0)
                 | (bus_cap ? BVALID_M : '0);
  assign clr_vec = sw_clr
                 | (mem_cap ? BVALID_M : '0)
                 | (bus_cap ? MVALID_M : '0);

  fault_w1c_reg #(.W(DW), .KEEP(STAT_MASK)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .q_o   (stat_q)
  );

  // single store shared by both address kinds
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 addr_q <= '0;
    else if (mem_cap || bus_cap) addr_q <= flt_addr;
  end
endmodule

// File: rtl/fault_read_mux.sv
module fault_read_mux
  import fault_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    lanes,
  input  logic [DW-1:0]    stat_w,
  input  logic [DW-1:0]    hard_w,
  input  logic [DW-1:0]    addr_w,
  input  logic [DW-1:0]    aux_w,
  output logic [DW-1:0]    rd_o
);
  logic [DW-1:0] sel;

  always_comb begin
    case (idx)
      IDX_STAT:             sel = stat_w;
      IDX_HARD:             sel = hard_w;
      IDX_MADDR, IDX_BADDR: sel = addr_w;
      IDX_AUX:              sel = aux_w;
      default:              sel = '0;
    endcase
  end

  assign rd_o = sel & lanes;
endmodule

// File: rtl/fault_capture.sv
module fault_capture
  import fault_pkg::*;
#(
  parameter int unsigned FA_W  = 32,
  parameter int unsigned AUX_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flt_valid,
  input  logic [CAUSE_W-1:0] flt_cause,
  input  logic [FA_W-1:0]    flt_addr,
  input  logic [HEV_W-1:0]   hf_evt,
  input  logic [AUX_W-1:0]   aux_in,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [IDX_W-1:0]   acc_idx,
  input  logic [LANES-1:0]   acc_be,
  input  logic [DW-1:0]      acc_wdata,
  output logic [DW-1:0]      rd_data
);
  logic              sw_wr;
  logic [DW-1:0]     lanes;
  logic [DW-1:0]     wr_ones;
  logic [DW-1:0]     clr_stat;
  logic [DW-1:0]     clr_hard;
  logic [AUX_W-1:0]  clr_aux;
  logic [DW-1:0]     stat_q;
  logic [DW-1:0]     hard_q;
  logic [AUX_W-1:0]  aux_q;
  logic [FA_W-1:0]   addr_q;
  logic              mem_cap;
  logic              bus_cap;
  logic [DW-1:0]     rd_mux;

  assign sw_wr    = acc_valid && acc_write;
  assign lanes    = lane_mask(acc_be);
  assign wr_ones  = acc_wdata & lanes;
  assign clr_stat = (sw_wr && acc_idx == IDX_STAT) ? wr_ones : '0;
  assign clr_hard = (sw_wr && acc_idx == IDX_HARD) ? wr_ones : '0;
  assign clr_aux  = (sw_wr && acc_idx == IDX_AUX)  ? AUX_W'(wr_ones) : '0;

  fault_status_bank #(.FA_W(FA_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .flt_valid (flt_valid),
    .flt_cause (flt_cause),
    .flt_addr  (flt_addr),
    .sw_clr    (clr_stat),
    .stat_q    (stat_q),
    .addr_q    (addr_q),
    .mem_cap   (mem_cap),
    .bus_cap   (bus_cap)
  );

  fault_w1c_reg #(.W(DW), .KEEP(HARD_MASK)) u_hard (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (hard_set(hf_evt)),
    .clr_i (clr_hard),
    .q_o   (hard_q)
  );

  fault_w1c_reg #(.W(AUX_W), .KEEP({AUX_W{1'b1}})) u_aux (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (aux_in),
    .clr_i (clr_aux),
    .q_o   (aux_q)
  );

  fault_read_mux u_rmux (
    .idx    (acc_idx),
    .lanes  (lanes),
    .stat_w (stat_q),
    .hard_w (hard_q),
    .addr_w (DW'(addr_q)),
    .aux_w  (DW'(aux_q)),
    .rd_o   (rd_mux)
  );

  assign rd_data = acc_valid ? rd_mux : '0;
endmodule

// File: rtl/fault_capture_chk.sv
module fault_capture_chk
  import fault_pkg::*;
#(
  parameter int unsigned FA_W  = 32,
  parameter int unsigned AUX_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flt_valid,
  input logic [CAUSE_W-1:0] flt_cause,
  input logic [FA_W-1:0]    flt_addr,
  input logic [HEV_W-1:0]   hf_evt,
  input logic [AUX_W-1:0]   aux_in,
  input logic               mem_cap,
  input logic               bus_cap,
  input logic [DW-1:0]      stat_q,
  input logic [DW-1:0]      hard_q,
  input logic [AUX_W-1:0]   aux_q,
  input logic [FA_W-1:0]    addr_q,
  input logic [DW-1:0]      clr_stat
);
  logic [DW-1:0] want_stat;
  logic [DW-1:0] want_hard;
  assign want_stat = cause_onehot(flt_valid, flt_cause);
  assign want_hard = hard_set(hf_evt);

  // R1, R5: a valid cause sets its flag even under a clear
  p_cause_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(want_stat)) == $past(want_stat)));

  // R2: cause flags fall only where software cleared them
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat_q) & ~$past(clr_stat) & CAUSE_MASK) & ~stat_q) == '0));

  // R6: a capturing cause loads the address
  p_addr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cap || bus_cap) |=> (addr_q == $past(flt_addr)));

  // R7: other cycles leave the address alone
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_cap || bus_cap) |=> $stable(addr_q));

  // R8: the two valid flags exclude each other
  p_valid_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_q[7] && stat_q[15]));

  // R9: escalation events land in their bits
  p_hard_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((hard_q & $past(want_hard)) == $past(want_hard)));

  // R10: auxiliary pulses are latched
  p_aux_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((aux_q & $past(aux_in)) == $past(aux_in)));

  // R11: reserved positions stay 0
  p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~STAT_MASK) == '0) && ((hard_q & ~HARD_MASK) == '0));
endmodule

bind fault_capture fault_capture_chk #(.FA_W(FA_W), .AUX_W(AUX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flt_valid (flt_valid),
  .flt_cause (flt_cause),
  .flt_addr  (flt_addr),
  .hf_evt    (hf_evt),
  .aux_in    (aux_in),
  .mem_cap   (mem_cap),
  .bus_cap   (bus_cap),
  .stat_q    (stat_q),
  .hard_q    (hard_q),
  .aux_q     (aux_q),
  .addr_q    (addr_q),
  .clr_stat  (clr_stat)
);

// File: tb/tb_fault_capture.sv
`timescale 1ns/1ps
module tb_fault_capture;
  localparam int unsigned AW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_valid = 1'b0;
  logic [4:0]  flt_cause = '0;
  logic [31:0] flt_addr = '0;
  logic [2:0]  hf_evt = '0;
  logic [AW-1:0] aux_in = '0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [2:0]  acc_idx = '0;
  logic [3:0]  acc_be = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  logic [31:0] m_stat = '0, m_hard = '0, m_addr = '0;
  logic [AW-1:0] m_aux = '0;

  always #2 clk = ~clk;

  fault_capture #(.FA_W(32), .AUX_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_cause(flt_cause),
    .flt_addr(flt_addr), .hf_evt(hf_evt), .aux_in(aux_in),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_idx(acc_idx),
    .acc_be(acc_be), .acc_wdata(acc_wdata), .rd_data(rd_data)
  );

  function automatic logic [31:0] flag_of(input logic [4:0] c);
    case (c)
      5'd0, 5'd1, 5'd3, 5'd4, 5'd8, 5'd9, 5'd10, 5'd11, 5'd12,
      5'd16, 5'd17, 5'd18, 5'd19, 5'd24, 5'd25: return 32'd1 << c;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] bytes_of(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] model_read(input logic [2:0] idx);
    case (idx)
      3'd0: return m_stat;
      3'd1: return m_hard;
      3'd2, 3'd3: return m_addr;
      3'd4: return {24'd0, m_aux};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic step(input logic ev, input logic [4:0] c, input logic [31:0] a,
                      input logic [2:0] h, input logic [AW-1:0] ax,
                      input logic wr, input logic [2:0] idx,
                      input logic [3:0] be, input logic [31:0] wd);
    logic [31:0] cl, ns, nh, na;
    logic [AW-1:0] nx;
    @(negedge clk);
    flt_valid = ev; flt_cause = c; flt_addr = a; hf_evt = h; aux_in = ax;
    acc_valid = wr; acc_write = wr; acc_idx = idx; acc_be = be; acc_wdata = wd;
    cl = wr ? (wd & bytes_of(be)) : 32'd0;
    ns = (m_stat & ~((idx == 3'd0) ? cl : 32'd0)) | (ev ? flag_of(c) : 32'd0);
    na = m_addr;
    if (ev && c == 5'd1) begin ns[7] = 1'b1; ns[15] = 1'b0; na = a; end
    if (ev && c == 5'd9) begin ns[15] = 1'b1; ns[7] = 1'b0; na = a; end
    nh = (m_hard & ~((idx == 3'd1) ? cl : 32'd0)) | {h[2], h[1], 28'd0, h[0], 1'b0};
    nx = (m_aux & ~((idx == 3'd4) ? cl[AW-1:0] : '0)) | ax;
    @(posedge clk);
    m_stat = ns; m_hard = nh; m_addr = na; m_aux = nx;
  endtask

  task automatic rd(input logic [2:0] idx, input logic [3:0] be, input string req);
    @(negedge clk);
    flt_valid = 0; hf_evt = '0; aux_in = '0;
    acc_valid = 1; acc_write = 0; acc_idx = idx; acc_be = be; acc_wdata = '0;
    #1;
    check(req, rd_data, model_read(idx) & bytes_of(be));
  endtask

  task automatic ev1(input logic [4:0] c, input logic [31:0] a);
    step(1, c, a, 3'd0, '0, 0, 3'd0, 4'h0, 32'd0);
  endtask

  task automatic wr1(input logic [2:0] idx, input logic [3:0] be, input logic [31:0] wd);
    step(0, 5'd0, 32'd0, 3'd0, '0, 1, idx, be, wd);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R12 reset values
    for (int i = 0; i < 8; i++) rd(i[2:0], 4'hF, "R12 reset");

    // R1 cause decoding
    ev1(5'd25, 32'h0); rd(3'd0, 4'hF, "R1 cause 25");
    check("R1 explicit", rd_data, 32'h0200_0000);
    ev1(5'd7, 32'h0);  rd(3'd0, 4'hF, "R1 code 7 ignored");
    ev1(5'd31, 32'h0); rd(3'd0, 4'hF, "R1 code 31 ignored");

    // R2 several flags coexist
    ev1(5'd0, 32'h0); ev1(5'd16, 32'h0); rd(3'd0, 4'hF, "R2 multi");

    // R3 write zero no effect, write one clears
    wr1(3'd0, 4'hF, 32'h0); rd(3'd0, 4'hF, "R3 zero write");
    wr1(3'd0, 4'hF, 32'h0001_0000); rd(3'd0, 4'hF, "R3 clear bit16");

    // R4 lane-limited clear and reads
    ev1(5'd3, 32'h0); ev1(5'd8, 32'h0); ev1(5'd10, 32'h0);
    wr1(3'd0, 4'b0010, 32'hFFFF_FFFF); rd(3'd0, 4'hF, "R4 byte1 clear");
    rd(3'd0, 4'b0001, "R4 byte0 read");
    rd(3'd0, 4'b1100, "R4 upper half read");

    // R5 set wins over clear
    step(1, 5'd4, 32'h0, 3'd0, '0, 1, 3'd0, 4'hF, 32'h0000_0010);
    rd(3'd0, 4'hF, "R5 collision");

    // R6 data violation captures address
    ev1(5'd1, 32'h1234_5678);
    rd(3'd0, 4'hF, "R6 valid bit7"); rd(3'd2, 4'hF, "R6 addr idx2");
    rd(3'd3, 4'hF, "R6 addr idx3");

    // R7 non-capturing causes
    ev1(5'd12, 32'hDEAD_0001); ev1(5'd11, 32'hDEAD_0002);
    ev1(5'd0, 32'hDEAD_0003);  ev1(5'd8, 32'hDEAD_0004);
    rd(3'd2, 4'hF, "R7 addr kept");

    // R8 precise error takes over
    ev1(5'd9, 32'hCAFE_F00D);
    rd(3'd0, 4'hF, "R8 bit15 set bit7 cleared"); rd(3'd3, 4'hF, "R8 addr");
    ev1(5'd1, 32'h0000_0400); rd(3'd0, 4'hF, "R8 back to bit7");

    // R9 escalation word
    step(0, 5'd0, 32'h0, 3'b111, '0, 0, 3'd0, 4'h0, 32'h0);
    rd(3'd1, 4'hF, "R9 all set");
    check("R9 explicit", rd_data, 32'hC000_0002);
    wr1(3'd1, 4'h8, 32'h4000_0000); rd(3'd1, 4'hF, "R9 clear bit30");

    // R10 auxiliary latch
    step(0, 5'd0, 32'h0, 3'd0, 8'h05, 0, 3'd0, 4'h0, 32'h0);
    step(0, 5'd0, 32'h0, 3'd0, 8'h00, 0, 3'd0, 4'h0, 32'h0);
    rd(3'd4, 4'hF, "R10 held");
    wr1(3'd4, 4'h1, 32'h1); rd(3'd4, 4'hF, "R10 clear bit0");

    // R11 ignored writes and unmapped reads
    wr1(3'd2, 4'hF, 32'hFFFF_FFFF); rd(3'd2, 4'hF, "R11 addr write ignored");
    wr1(3'd3, 4'hF, 32'hFFFF_FFFF); rd(3'd3, 4'hF, "R11 addr write ignored");
    for (int i = 5; i < 8; i++) rd(i[2:0], 4'hF, "R11 unmapped");
    rd(3'd4, 4'hE, "R11 aux upper lanes");

    // random mix
    for (int k = 0; k < 800; k++) begin
      logic ev, wr;
      logic [4:0] c;
      logic [2:0] h, idx;
      logic [AW-1:0] ax;
      ev  = ($urandom % 2) == 0;
      c   = 5'($urandom % 32);
      if (($urandom % 3) == 0) c = (($urandom % 2) == 0) ? 5'd1 : 5'd9;
      h   = (($urandom % 6) == 0) ? 3'($urandom) : 3'd0;
      ax  = (($urandom % 5) == 0) ? AW'($urandom) : '0;
      wr  = ($urandom % 3) == 0;
      idx = 3'($urandom % 8);
      step(ev, c, $urandom, h, ax, wr, idx, 4'($urandom), $urandom);
      rd(3'($urandom % 8), 4'($urandom), "random R2 R3 R4 R5 R8 R10");
    end

    done = 1'b1;
    finish_run();
  end
endmodule